// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit carries out the two trap-return operations of a processor core: the return to a supervisor-level caller and the return to a machine-level caller. A single-cycle request names which of the two is wanted. The unit judges whether the return is legal in the current privilege and virtualization context. If it is legal, it pops the interrupt-enable and previous-privilege stacks held in the status words, chooses the privilege and virtualization mode to resume in, and restores the expected-landing-pad flag used by forward control-flow protection. It also hands back the saved return PC.

The status words arrive as inputs and leave as outputs. The surrounding core owns the registers and writes back what the unit reports. The unit uses compact layouts of its own for these words. When a return enters or leaves a virtualized guest and the hypervisor shadow registers have to be exchanged, the unit only raises a swap request; the exchange itself happens elsewhere. Every result is registered and appears exactly one clock after the request. Results are committed as a whole, or not at all when an exception is reported.

Machine status word layout (16 bits): bit0 supervisor interrupt enable, bit1 machine interrupt enable, bit2 supervisor previous enable, bit3 machine previous enable, bit4 supervisor previous privilege, bits6:5 machine previous privilege, bit7 modify-privilege, bit8 trap-supervisor-return, bit9 machine previous virtualization, bit10 supervisor saved landing-pad, bit11 machine saved landing-pad, bits15:12 reserved (passed through). Hypervisor status word (2 bits): bit0 supervisor previous virtualization, bit1 virtual trap-supervisor-return. Privilege encoding: 0 user, 1 supervisor, 3 machine.

Top module: `trap_return_unit`

## Requirements
- R1: While reset is asserted, done_o, commit_o, exc_o and swap_o are 0.
- R2: A request with req_valid_i=1 produces done_o=1 exactly one clock later, with exactly one of commit_o and exc_o set. With no request, done_o is 0 in the next cycle.
- R3: A supervisor return with cur_priv_i=0, or a machine return with cur_priv_i other than 3, reports cause 2 (illegal instruction). This check takes precedence over every other check.
- R4: When has_c_i=0 and bits 1:0 of the selected saved PC are non-zero, the unit reports cause 0 (misaligned return address). This check comes right after the R3 check.
- R5: A supervisor return with the trap-supervisor-return bit (bit8) set and cur_priv_i not 3 reports cause 2. Otherwise, when cur_virt_i=1 and the virtual trap-supervisor-return bit (hstat bit1) is set, it reports cause 22 (virtual instruction).
- R6: A committed supervisor return copies bit2 into bit0, sets bit2, clears bit4, and resumes at privilege {0, old bit4}. It clears bit7 when spec_new_i=1. All other bits pass through unchanged.
- R7: A committed supervisor return with has_h_i=1 and cur_virt_i=0 takes the new virtualization from hstat bit0, clears that bit, and raises swap_o when that bit was 1. In every other case the virtualization and the hypervisor status stay unchanged, and swap_o is 0.
- R8: A committed machine return copies bit3 into bit1, sets bit3, sets bits6:5 to 0 when has_u_i=1 and to 3 otherwise, clears bit9, and resumes at the privilege held in old bits6:5.
- R9: A committed machine return sets virt_o to old bit9 AND (old bits6:5 not 3), and sets swap_o when has_h_i=1 and virt_o=1. It clears bit7 only when spec_new_i=1 and old bits6:5 are not 3.
- R10: A machine return with pmp_impl_i=1, pmp_empty_i=1 and old bits6:5 not 3 reports cause 1 (access fault), after the R3 and R4 checks.
- R11: On commit, elp_o takes the saved landing-pad bit of the executed return (bit10 for supervisor, bit11 for machine) when fcfi_en_i[new privilege] is 1, and keeps cur_elp_i otherwise. That saved bit is cleared in mstat_o.
- R12: When an exception is reported, nothing is committed: mstat_o, hstat_o, priv_o, virt_o and elp_o equal the request's inputs, swap_o is 0 and ret_pc_o is 0.
- R13: On commit, ret_pc_o equals sepc_i for a supervisor return and mepc_i for a machine return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Return request strobe |
| req_is_mret_i | input | 1 | 1 for machine return, 0 for supervisor return |
| cur_priv_i | input | 2 | Current privilege |
| cur_virt_i | input | 1 | Current virtualization flag |
| cur_elp_i | input | 1 | Current expected-landing-pad flag |
| mstat_i | input | 16 | Machine status word |
| hstat_i | input | 2 | Hypervisor status word |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| has_c_i | input | 1 | Compressed instructions present |
| has_u_i | input | 1 | User mode present |
| has_h_i | input | 1 | Hypervisor present |
| pmp_impl_i | input | 1 | Physical memory protection implemented |
| pmp_empty_i | input | 1 | No protection rules configured |
| spec_new_i | input | 1 | Newer privileged rules (modify-privilege clear) apply |
| fcfi_en_i | input | 4 | Forward control-flow protection enable, indexed by privilege |
| done_o | output | 1 | Result valid |
| commit_o | output | 1 | Return committed |
| exc_o | output | 1 | Exception reported |
| cause_o | output | 5 | Exception cause |
| mstat_o | output | 16 | New machine status word |
| hstat_o | output | 2 | New hypervisor status word |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization flag |
| elp_o | output | 1 | New expected-landing-pad flag |
| ret_pc_o | output | XLEN | Return PC |
| swap_o | output | 1 | Request to swap hypervisor shadow registers |

## Verification
Cycle-level properties watch, on every return, the one-cycle latency and the single-outcome rule. They also watch the precedence of the low-privilege trap, the fact that a failed return leaves the state untouched, the stack bits that each return kind forces, the saved landing-pad clear, and the rule that a return to machine mode is never virtualized. What the properties cannot see is the ordering among the lower-priority causes, the previous-virtualization and swap decision, the conditional modify-privilege clear, and the landing-pad restore that depends on the per-privilege enable. Those are covered by the bench's scenarios, which compare every output field against values derived from the requirements.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

    localparam int STAT_W  = 16;
    localparam int HSTAT_W = 2;
    localparam int CAUSE_W = 5;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_R = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ACCESS   = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       m_lp;
        logic       s_lp;
        logic       m_pv;
        logic       tsr;
        logic       mprv;
        logic [1:0] m_pp;
        logic       s_pp;
        logic       m_pie;
        logic       s_pie;
        logic       m_ie;
        logic       s_ie;
    } mstat_t;

    typedef struct packed {
        logic vtsr;
        logic s_pv;
    } hstat_t;

    typedef struct packed {
        logic               fault;
        logic [CAUSE_W-1:0] cause;
    } fault_t;

endpackage

// File: rtl/trap_ret_legal.sv
module trap_ret_legal
    import trap_ret_pkg::*;
(
    input  logic       is_mret,
    input  priv_e      cur_priv,
    input  logic       cur_virt,
    input  logic       tsr,
    input  logic       vtsr,
    input  logic [1:0] pc_low,
    input  logic       has_c,
    input  logic       pmp_impl,
    input  logic       pmp_empty,
    input  priv_e      mret_target,
    output fault_t     fault_o
);

    logic misalign;

    always_comb begin
        misalign = !has_c && (pc_low != 2'b00);
        fault_o  = '0;
        if (is_mret) begin
            if (cur_priv != PRIV_M) begin
                fault_o = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            end else if (misalign) begin
                fault_o = '{fault: 1'b1, cause: CAUSE_MISALIGN};
            end else if (pmp_impl && pmp_empty && (mret_target != PRIV_M)) begin
                fault_o = '{fault: 1'b1, cause: CAUSE_ACCESS};
            end
        end else begin
            if (cur_priv == PRIV_U) begin
                fault_o = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            end else if (misalign) begin
                fault_o = '{fault: 1'b1, cause: CAUSE_MISALIGN};
            end else if (tsr && (cur_priv != PRIV_M)) begin
                fault_o = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            end else if (cur_virt && vtsr) begin
                fault_o = '{fault: 1'b1, cause: CAUSE_VIRT};
            end
        end
    end

endmodule

// File: rtl/trap_ret_sret_pop.sv
module trap_ret_sret_pop
    import trap_ret_pkg::*;
(
    input  mstat_t mstat_i,
    input  hstat_t hstat_i,
    input  logic   cur_virt,
    input  logic   has_h,
    input  logic   spec_new,
    output mstat_t mstat_o,
    output hstat_t hstat_o,
    output priv_e  priv_o,
    output logic   virt_o,
    output logic   swap_o,
    output logic   saved_lp_o
);

    always_comb begin
        mstat_o       = mstat_i;
        hstat_o       = hstat_i;
        priv_o        = mstat_i.s_pp ? PRIV_S : PRIV_U;
        mstat_o.s_ie  = mstat_i.s_pie;
        mstat_o.s_pie = 1'b1;
        mstat_o.s_pp  = 1'b0;
        if (spec_new) begin
            mstat_o.mprv = 1'b0;
        end
        saved_lp_o    = mstat_i.s_lp;
        mstat_o.s_lp  = 1'b0;
        virt_o        = cur_virt;
        swap_o        = 1'b0;
        if (has_h && !cur_virt) begin
            virt_o       = hstat_i.s_pv;
            swap_o       = hstat_i.s_pv;
            hstat_o.s_pv = 1'b0;
        end
    end

endmodule

// File: rtl/trap_ret_mret_pop.sv
module trap_ret_mret_pop
    import trap_ret_pkg::*;
(
    input  mstat_t mstat_i,
    input  logic   has_u,
    input  logic   has_h,
    input  logic   spec_new,
    output mstat_t mstat_o,
    output priv_e  priv_o,
    output logic   virt_o,
    output logic   swap_o,
    output logic   saved_lp_o
);

    priv_e prev;

    always_comb begin
        prev          = priv_e'(mstat_i.m_pp);
        priv_o        = prev;
        virt_o        = mstat_i.m_pv && (prev != PRIV_M);
        swap_o        = has_h && virt_o;
        mstat_o       = mstat_i;
        mstat_o.m_ie  = mstat_i.m_pie;
        mstat_o.m_pie = 1'b1;
        mstat_o.m_pp  = has_u ? PRIV_U : PRIV_M;
        mstat_o.m_pv  = 1'b0;
        if (spec_new && (prev != PRIV_M)) begin
            mstat_o.mprv = 1'b0;
        end
        saved_lp_o    = mstat_i.m_lp;
        mstat_o.m_lp  = 1'b0;
    end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trap_ret_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic                 req_is_mret_i,
    input  logic [1:0]           cur_priv_i,
    input  logic                 cur_virt_i,
    input  logic                 cur_elp_i,
    input  logic [STAT_W-1:0]    mstat_i,
    input  logic [HSTAT_W-1:0]   hstat_i,
    input  logic [XLEN-1:0]      sepc_i,
    input  logic [XLEN-1:0]      mepc_i,
    input  logic                 has_c_i,
    input  logic                 has_u_i,
    input  logic                 has_h_i,
    input  logic                 pmp_impl_i,
    input  logic                 pmp_empty_i,
    input  logic                 spec_new_i,
    input  logic [3:0]           fcfi_en_i,
    output logic                 done_o,
    output logic                 commit_o,
    output logic                 exc_o,
    output logic [CAUSE_W-1:0]   cause_o,
    output logic [STAT_W-1:0]    mstat_o,
    output logic [HSTAT_W-1:0]   hstat_o,
    output logic [1:0]           priv_o,
    output logic                 virt_o,
    output logic                 elp_o,
    output logic [XLEN-1:0]      ret_pc_o,
    output logic                 swap_o
);

    typedef struct packed {
        logic               done;
        logic               commit;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
        mstat_t             mstat;
        hstat_t             hstat;
        priv_e              priv;
        logic               virt;
        logic               elp;
        logic [XLEN-1:0]    pc;
        logic               swap;
    } result_t;

    result_t res_d, res_q;

    mstat_t mstat_in;
    hstat_t hstat_in;
    priv_e  cur_priv;
    logic [XLEN-1:0] sel_pc;

    assign mstat_in = mstat_t'(mstat_i);
    assign hstat_in = hstat_t'(hstat_i);
    assign cur_priv = priv_e'(cur_priv_i);
    assign sel_pc   = req_is_mret_i ? mepc_i : sepc_i;

    // Supervisor-return stack pop
    mstat_t s_mstat;
    hstat_t s_hstat;
    priv_e  s_priv;
    logic   s_virt, s_swap, s_lp;

    trap_ret_sret_pop u_sret (
        .mstat_i    (mstat_in),
        .hstat_i    (hstat_in),
        .cur_virt   (cur_virt_i),
        .has_h      (has_h_i),
        .spec_new   (spec_new_i),
        .mstat_o    (s_mstat),
        .hstat_o    (s_hstat),
        .priv_o     (s_priv),
        .virt_o     (s_virt),
        .swap_o     (s_swap),
        .saved_lp_o (s_lp)
    );

    // Machine-return stack pop
    mstat_t m_mstat;
    priv_e  m_priv;
    logic   m_virt, m_swap, m_lp;

    trap_ret_mret_pop u_mret (
        .mstat_i    (mstat_in),
        .has_u      (has_u_i),
        .has_h      (has_h_i),
        .spec_new   (spec_new_i),
        .mstat_o    (m_mstat),
        .priv_o     (m_priv),
        .virt_o     (m_virt),
        .swap_o     (m_swap),
        .saved_lp_o (m_lp)
    );

    // Legality and exception priority
    fault_t fault;

    trap_ret_legal u_legal (
        .is_mret     (req_is_mret_i),
        .cur_priv    (cur_priv),
        .cur_virt    (cur_virt_i),
        .tsr         (mstat_in.tsr),
        .vtsr        (hstat_in.vtsr),
        .pc_low      (sel_pc[1:0]),
        .has_c       (has_c_i),
        .pmp_impl    (pmp_impl_i),
        .pmp_empty   (pmp_empty_i),
        .mret_target (m_priv),
        .fault_o     (fault)
    );

    always_comb begin
        res_d        = res_q;
        res_d.done   = 1'b0;
        res_d.commit = 1'b0;
        res_d.exc    = 1'b0;
        res_d.swap   = 1'b0;
        if (req_valid_i) begin
            res_d.done = 1'b1;
            if (fault.fault) begin
                res_d.exc   = 1'b1;
                res_d.cause = fault.cause;
                res_d.mstat = mstat_in;
                res_d.hstat = hstat_in;
                res_d.priv  = cur_priv;
                res_d.virt  = cur_virt_i;
                res_d.elp   = cur_elp_i;
                res_d.pc    = '0;
            end else begin
                res_d.commit = 1'b1;
                res_d.cause  = '0;
                res_d.pc     = sel_pc;
                if (req_is_mret_i) begin
                    res_d.mstat = m_mstat;
                    res_d.hstat = hstat_in;
                    res_d.priv  = m_priv;
                    res_d.virt  = m_virt;
                    res_d.swap  = m_swap;
                    res_d.elp   = fcfi_en_i[m_priv] ? m_lp : cur_elp_i;
                end else begin
                    res_d.mstat = s_mstat;
                    res_d.hstat = s_hstat;
                    res_d.priv  = s_priv;
                    res_d.virt  = s_virt;
                    res_d.swap  = s_swap;
                    res_d.elp   = fcfi_en_i[s_priv] ? s_lp : cur_elp_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign done_o   = res_q.done;
    assign commit_o = res_q.commit;
    assign exc_o    = res_q.exc;
    assign cause_o  = res_q.cause;
    assign mstat_o  = res_q.mstat;
    assign hstat_o  = res_q.hstat;
    assign priv_o   = res_q.priv;
    assign virt_o   = res_q.virt;
    assign elp_o    = res_q.elp;
    assign ret_pc_o = res_q.pc;
    assign swap_o   = res_q.swap;

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !done_o || $past(req_valid_i)); // R1

    AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> done_o); // R2

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (commit_o ^ exc_o)); // R2

    AST_LOW_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (req_is_mret_i ? (cur_priv_i != 2'd3) : (cur_priv_i == 2'd0)))
        |=> (exc_o && cause_o == CAUSE_ILLEGAL)); // R3

    AST_FAULT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (!exc_o || (mstat_o == $past(mstat_i) && priv_o == $past(cur_priv_i)
                                    && virt_o == $past(cur_virt_i) && !swap_o))); // R12

    AST_SRET_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !$past(req_is_mret_i)) |-> (mstat_o[2] && !mstat_o[4] && !mstat_o[10])); // R6

    AST_MRET_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && $past(req_is_mret_i)) |-> (mstat_o[3] && !mstat_o[9] && !mstat_o[11])); // R8

    AST_MRET_NO_VIRT_M: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && $past(req_is_mret_i) && priv_o == 2'd3) |-> !virt_o); // R9

    AST_SWAP_ONLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |-> (commit_o && virt_o != $past(cur_virt_i))); // R7

endmodule

// File: tb/trap_return_unit_bench.sv
`timescale 1ns/1ps
module trap_return_unit_bench;

    localparam int XLEN = 32;
    localparam int W    = 1 + 1 + 5 + 16 + 2 + 2 + 1 + 1 + XLEN + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            req_valid, req_mret, b_virt, b_elp;
    logic [1:0]      b_priv;
    logic [15:0]     b_mstat;
    logic [1:0]      b_hstat;
    logic [XLEN-1:0] b_sepc, b_mepc;
    logic            b_has_c, b_has_u, b_has_h, b_pmp_impl, b_pmp_empty, b_spec;
    logic [3:0]      b_fcfi;

    logic            done_o, commit_o, exc_o, virt_o, elp_o, swap_o;
    logic [4:0]      cause_o;
    logic [15:0]     mstat_o;
    logic [1:0]      hstat_o, priv_o;
    logic [XLEN-1:0] ret_pc_o;

    trap_return_unit #(.XLEN(XLEN)) u_trap_return_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_is_mret_i(req_mret),
        .cur_priv_i(b_priv), .cur_virt_i(b_virt), .cur_elp_i(b_elp),
        .mstat_i(b_mstat), .hstat_i(b_hstat), .sepc_i(b_sepc), .mepc_i(b_mepc),
        .has_c_i(b_has_c), .has_u_i(b_has_u), .has_h_i(b_has_h),
        .pmp_impl_i(b_pmp_impl), .pmp_empty_i(b_pmp_empty), .spec_new_i(b_spec),
        .fcfi_en_i(b_fcfi),
        .done_o(done_o), .commit_o(commit_o), .exc_o(exc_o), .cause_o(cause_o),
        .mstat_o(mstat_o), .hstat_o(hstat_o), .priv_o(priv_o), .virt_o(virt_o),
        .elp_o(elp_o), .ret_pc_o(ret_pc_o), .swap_o(swap_o)
    );

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model();
        logic [15:0] m;
        logic [1:0]  h, np;
        logic        nv, ne, sw, ex, misal, saved;
        logic [4:0]  c;
        logic [XLEN-1:0] pc;
        m = b_mstat; h = b_hstat; ex = 1'b0; c = 5'd0;
        np = 2'd0; nv = 1'b0; sw = 1'b0; saved = 1'b0;
        pc = req_mret ? b_mepc : b_sepc;
        misal = !b_has_c && (pc[1:0] != 2'b00);
        if (req_mret) begin
            if (b_priv != 2'd3) begin ex = 1; c = 5'd2; end
            else if (misal) begin ex = 1; c = 5'd0; end
            else if (b_pmp_impl && b_pmp_empty && m[6:5] != 2'd3) begin ex = 1; c = 5'd1; end
        end else begin
            if (b_priv == 2'd0) begin ex = 1; c = 5'd2; end
            else if (misal) begin ex = 1; c = 5'd0; end
            else if (m[8] && b_priv != 2'd3) begin ex = 1; c = 5'd2; end
            else if (b_virt && h[1]) begin ex = 1; c = 5'd22; end
        end
        if (ex)
            return {1'b0, 1'b1, c, b_mstat, b_hstat, b_priv, b_virt, b_elp, {XLEN{1'b0}}, 1'b0};
        if (req_mret) begin
            np = m[6:5];
            nv = m[9] && (np != 2'd3);
            sw = b_has_h && nv;
            saved = m[11];
            m[1] = m[3]; m[3] = 1'b1;
            m[6:5] = b_has_u ? 2'd0 : 2'd3;
            m[9] = 1'b0;
            if (b_spec && np != 2'd3) m[7] = 1'b0;
            m[11] = 1'b0;
        end else begin
            np = {1'b0, m[4]};
            nv = b_virt;
            saved = m[10];
            m[0] = m[2]; m[2] = 1'b1; m[4] = 1'b0;
            if (b_spec) m[7] = 1'b0;
            m[10] = 1'b0;
            if (b_has_h && !b_virt) begin nv = h[0]; sw = h[0]; h[0] = 1'b0; end
        end
        ne = b_fcfi[np] ? saved : b_elp;
        return {1'b1, 1'b0, 5'd0, m, h, np, nv, ne, pc, sw};
    endfunction

    task automatic defaults();
        req_mret = 0; b_priv = 2'd3; b_virt = 0; b_elp = 0;
        b_mstat = 16'h0000; b_hstat = 2'b00;
        b_sepc = 32'h0000_1000; b_mepc = 32'h0000_2000;
        b_has_c = 1; b_has_u = 1; b_has_h = 0;
        b_pmp_impl = 0; b_pmp_empty = 0; b_spec = 0; b_fcfi = 4'h0;
    endtask

    // Driver: called just after a falling edge with inputs already set
    task automatic fire(input string tag);
        exp_q.push_back(model());
        tag_q.push_back(tag);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected result actual=1 expected=0");
            end else begin
                check(tag_q.pop_front(),
                      {commit_o, exc_o, cause_o, mstat_o, hstat_o, priv_o, virt_o, elp_o, ret_pc_o, swap_o},
                      exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        req_valid = 0;
        defaults();
        repeat (3) @(negedge clk);
        check("R1 reset", {{(W-4){1'b0}}, done_o, commit_o, exc_o, swap_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R13: supervisor return from S to S with stack bits set
        defaults(); b_priv = 2'd1; b_mstat = 16'hF094; b_spec = 1; b_sepc = 32'h0000_4444;
        fire("R6 R13 sret basic");
        defaults(); b_priv = 2'd3; b_mstat = 16'h0080; b_spec = 0;
        fire("R6 sret from M, no MPRV clear");
        // R3
        defaults(); b_priv = 2'd0;
        fire("R3 sret from U");
        defaults(); req_mret = 1; b_priv = 2'd1; b_has_c = 0; b_mepc = 32'h3;
        fire("R3 R12 mret from S precedes misalign");
        // R4
        defaults(); b_priv = 2'd1; b_has_c = 0; b_sepc = 32'h0000_1002;
        fire("R4 sret misaligned");
        defaults(); b_priv = 2'd1; b_has_c = 1; b_sepc = 32'h0000_1002;
        fire("R4 R13 misaligned ok with compressed");
        // R5
        defaults(); b_priv = 2'd1; b_mstat = 16'h0100;
        fire("R5 tsr traps from S");
        defaults(); b_priv = 2'd3; b_mstat = 16'h0100;
        fire("R5 tsr ignored in M");
        defaults(); b_priv = 2'd1; b_virt = 1; b_hstat = 2'b10; b_elp = 1;
        fire("R5 R12 virtual tsr");
        // R7
        defaults(); b_priv = 2'd1; b_has_h = 1; b_hstat = 2'b01; b_mstat = 16'h0010;
        fire("R7 sret into guest swaps");
        defaults(); b_priv = 2'd1; b_has_h = 1; b_virt = 1; b_hstat = 2'b01;
        fire("R7 sret inside guest keeps virt");
        // R8
        defaults(); req_mret = 1; b_mstat = 16'h0008;
        fire("R8 mret to U with user mode");
        defaults(); req_mret = 1; b_has_u = 0; b_mstat = 16'h0060;
        fire("R8 mret without user mode");
        // R9
        defaults(); req_mret = 1; b_has_h = 1; b_spec = 1; b_mstat = 16'h02A0;
        fire("R9 mret into guest S");
        defaults(); req_mret = 1; b_has_h = 1; b_spec = 1; b_mstat = 16'h02E0;
        fire("R9 mret to M keeps MPRV, no virt");
        // R10
        defaults(); req_mret = 1; b_pmp_impl = 1; b_pmp_empty = 1; b_mstat = 16'h0000;
        fire("R10 empty protection");
        defaults(); req_mret = 1; b_pmp_impl = 1; b_pmp_empty = 1; b_mstat = 16'h0060;
        fire("R10 empty protection to M ok");
        defaults(); req_mret = 1; b_pmp_impl = 1; b_pmp_empty = 1; b_has_c = 0; b_mepc = 32'h1;
        fire("R10 misalign outranks access");
        // R11
        defaults(); b_priv = 2'd1; b_mstat = 16'h0410; b_fcfi = 4'b0010;
        fire("R11 sret restores landing pad");
        defaults(); b_priv = 2'd1; b_mstat = 16'h0410; b_fcfi = 4'b0001; b_elp = 0;
        fire("R11 sret landing pad disabled");
        defaults(); req_mret = 1; b_mstat = 16'h0800; b_fcfi = 4'b0001; b_elp = 0;
        fire("R11 mret restores landing pad");

        // R2 idle: no request gives no result
        @(negedge clk);
        @(negedge clk);
        check("R2 idle", {{(W-1){1'b0}}, done_o}, '0);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending actual=%0d expected=0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule